// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block holds the main command and status word of a network controller, together with three plain companion registers reached through an indirect select. The host talks to it through two locations. Location 1 holds a 2-bit register select, and location 0 is a data window onto whichever register the select points at. Select 0 is the command and status word. Selects 1, 2 and 3 are simple 16-bit storage.

The command and status word mixes several kinds of access. Event flags are raised by single-cycle pulses from the rest of the controller and are cleared when the host writes a one to them. Command bits can be set by the host but not cleared by it. The enable bit takes whatever value is written. Two summary bits are derived from the event flags. The interrupt line is the interrupt summary gated by the enable bit. When the controller reports that initialization is complete, the block also loads the receiver-on and transmitter-on states. A memory error forces both of these off.

Top module: `netctl_csr`

## Requirements
- R1: Bit positions of word 0: 14 babble, 13 collision, 12 missed frame, 11 memory error, 10 receive interrupt, 9 transmit interrupt, 8 init done. A host write of 1 to any of these positions through the data window with select 0 clears that flag. A write of 0 leaves it unchanged.
- R2: A one-cycle pulse on an event input sets the matching flag on the next clock. When a pulse and a host clear of the same flag arrive in the same cycle, the flag ends up set.
- R3: Bit 1 START, bit 0 INIT and bit 3 TXDEMAND are set by writing 1 and are never cleared by a host write of 0. Writing 1 to START or INIT clears STOP (bit 2).
- R4: Writing 1 to STOP sets STOP and clears START and INIT. This holds even when START or INIT is written as 1 in the same write.
- R5: Bit 6 interrupt enable takes the value written on every write to word 0.
- R6: Bit 15 is the OR of babble, collision, missed frame and memory error. Bit 7 is the OR of babble, missed frame, memory error, receive interrupt, transmit interrupt and init done. A collision alone does not set bit 7.
- R7: While the memory error flag is set, receiver-on (bit 5) and transmitter-on (bit 4) read 0.
- R8: An init-done pulse clears INIT and loads receiver-on from `init_rx_en` and transmitter-on from `init_tx_en`. While STOP is set, the init-done flag (bit 8) stays clear.
- R9: `irq` is high exactly when both bit 7 and bit 6 are set.
- R10: After reset, word 0 reads 0x0004, the select reads 0, selects 1 to 3 read 0 and `irq` is low.
- R11: A write to location 1 stores the low 2 bits of the data as the select, and a read of location 1 returns it. Writes through the data window to selects 1 to 3 store all 16 bits, and each register keeps its own value.
- R12: A pulse on `tdmd_clr` clears TXDEMAND. A host write setting TXDEMAND in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = data window, 1 = register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` |
| ev_babble | input | 1 | Babble event pulse |
| ev_coll | input | 1 | Collision error event pulse |
| ev_miss | input | 1 | Missed frame event pulse |
| ev_merr | input | 1 | Memory error event pulse |
| ev_rxdone | input | 1 | Receive done event pulse |
| ev_txdone | input | 1 | Transmit done event pulse |
| ev_initdone | input | 1 | Initialization complete pulse |
| init_rx_en | input | 1 | Receiver-on value loaded at init done |
| init_tx_en | input | 1 | Transmitter-on value loaded at init done |
| tdmd_clr | input | 1 | Transmitter acknowledge of TXDEMAND |
| csr_value | output | 16 | Current value of word 0 |
| ctl_start | output | 1 | START command |
| ctl_stop | output | 1 | STOP command |
| ctl_init | output | 1 | INIT command |
| ctl_tdmd | output | 1 | Transmit demand |
| ctl_inea | output | 1 | Interrupt enable |
| rx_on | output | 1 | Receiver on |
| tx_on | output | 1 | Transmitter on |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes STOP together with START and INIT in one word. A design with the priority reversed would come out running. It also writes zeros over command bits to catch a design that treats them as plain storage. It lines up an event pulse with a host clear of the same flag, and a transmitter acknowledge with a host demand, to catch a design where the clear wins and the event is lost. It raises a collision alone to check that the interrupt summary stays low. It raises a memory error while the receiver and transmitter are on, to catch a design that leaves them running. It fires init done while stopped, where a wrong design would show the init-done flag alongside STOP.

// File: rtl/netctl_csr_pkg.sv
package netctl_csr_pkg;
  localparam int CSR_W = 16;

  localparam int BIT_INIT     = 0;
  localparam int BIT_START    = 1;
  localparam int BIT_STOP     = 2;
  localparam int BIT_TXDEMAND = 3;
  localparam int BIT_TXON     = 4;
  localparam int BIT_RXON     = 5;
  localparam int BIT_IEN      = 6;
  localparam int BIT_IRQSUM   = 7;
  localparam int BIT_INITDONE = 8;
  localparam int BIT_ERRSUM   = 15;

  // event flags occupy bits EVT_BASE .. EVT_BASE+N_EVT-1
  localparam int EVT_BASE = 8;
  localparam int N_EVT    = 7;
  // index within the event vector
  localparam int EV_INITDONE = 0;
  localparam int EV_TXINT    = 1;
  localparam int EV_RXINT    = 2;
  localparam int EV_MEMERR   = 3;
  localparam int EV_MISSED   = 4;
  localparam int EV_COLL     = 5;
  localparam int EV_BABBLE   = 6;

  typedef struct packed {
    logic start;
    logic stop;
    logic init;
    logic tdmd;
    logic inea;
    logic rxon;
    logic txon;
  } cmd_t;
endpackage

// File: rtl/netctl_evt_bit.sv
module netctl_evt_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic d_o,
  output logic q_o
);
  logic q;

  // a set beats a host clear, a hold beats both
  always_comb begin
    d_o = hold_i ? 1'b0 : (set_i | (q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_o;
  end

  assign q_o = q;
endmodule

// File: rtl/netctl_cmd_reg.sv
module netctl_cmd_reg
  import netctl_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  logic             initdone_ev,
  input  logic             init_rx_en,
  input  logic             init_tx_en,
  input  logic             tdmd_clr,
  input  logic             memerr_next,
  output cmd_t             cmd_q,
  output logic             stop_next
);
  cmd_t cmd_d;
  cmd_t cmd_r;

  always_comb begin
    cmd_d      = cmd_r;
    cmd_d.tdmd = cmd_r.tdmd & ~tdmd_clr;
    if (initdone_ev) begin
      cmd_d.init = 1'b0;
      cmd_d.rxon = init_rx_en;
      cmd_d.txon = init_tx_en;
    end
    if (wr_en) begin
      if (wdata[BIT_TXDEMAND]) cmd_d.tdmd = 1'b1;
      if (wdata[BIT_START]) begin
        cmd_d.start = 1'b1;
        cmd_d.stop  = 1'b0;
      end
      if (wdata[BIT_INIT]) begin
        cmd_d.init = 1'b1;
        cmd_d.stop = 1'b0;
      end
      if (wdata[BIT_STOP]) begin
        cmd_d.stop  = 1'b1;
        cmd_d.start = 1'b0;
        cmd_d.init  = 1'b0;
      end
      cmd_d.inea = wdata[BIT_IEN];
    end
    if (memerr_next) begin
      cmd_d.rxon = 1'b0;
      cmd_d.txon = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r <= '{start: 1'b0, stop: 1'b1, init: 1'b0, tdmd: 1'b0,
                 inea: 1'b0, rxon: 1'b0, txon: 1'b0};
    end else begin
      cmd_r <= cmd_d;
    end
  end

  assign cmd_q     = cmd_r;
  assign stop_next = cmd_d.stop;
endmodule

// File: rtl/netctl_aux_bank.sv
module netctl_aux_bank #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NUM_REGS = 1 << SEL_W;

  logic [DATA_W-1:0] rd_arr [NUM_REGS];

  assign rd_arr[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = we && (sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata;
    end
    assign rd_arr[i] = q;
  end

  assign rdata = rd_arr[sel];
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
  import netctl_csr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_addr,
  input  logic [CSR_W-1:0] host_wdata,
  output logic [CSR_W-1:0] host_rdata,
  input  logic             ev_babble,
  input  logic             ev_coll,
  input  logic             ev_miss,
  input  logic             ev_merr,
  input  logic             ev_rxdone,
  input  logic             ev_txdone,
  input  logic             ev_initdone,
  input  logic             init_rx_en,
  input  logic             init_tx_en,
  input  logic             tdmd_clr,
  output logic [CSR_W-1:0] csr_value,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_init,
  output logic             ctl_tdmd,
  output logic             ctl_inea,
  output logic             rx_on,
  output logic             tx_on,
  output logic             irq
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // host decode
  logic data_we, sel_we, csr0_we, aux_we;
  logic [SEL_W-1:0] sel_q, sel_d;
  assign data_we = host_we & ~host_addr;
  assign sel_we  = host_we &  host_addr;
  assign csr0_we = data_we & (sel_q == '0);
  assign aux_we  = data_we & (sel_q != '0);

  always_comb begin
    sel_d = sel_q;
    if (sel_we) sel_d = host_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end

  // event flags
  logic [N_EVT-1:0] ev_vec, stat_q, stat_d, stat_clr;
  logic             stop_next;
  assign ev_vec   = {ev_babble, ev_coll, ev_miss, ev_merr,
                     ev_rxdone, ev_txdone, ev_initdone};
  assign stat_clr = csr0_we ? host_wdata[EVT_BASE +: N_EVT] : '0;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    logic hold;
    if (i == EV_INITDONE) begin : g_hold
      assign hold = stop_next;
    end else begin : g_free
      assign hold = 1'b0;
    end
    netctl_evt_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (ev_vec[i]),
      .clr_i  (stat_clr[i]),
      .hold_i (hold),
      .d_o    (stat_d[i]),
      .q_o    (stat_q[i])
    );
  end

  // command bits
  cmd_t cmd_q;
  netctl_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (csr0_we),
    .wdata       (host_wdata),
    .initdone_ev (ev_initdone),
    .init_rx_en  (init_rx_en),
    .init_tx_en  (init_tx_en),
    .tdmd_clr    (tdmd_clr),
    .memerr_next (stat_d[EV_MEMERR]),
    .cmd_q       (cmd_q),
    .stop_next   (stop_next)
  );

  // plain registers behind selects 1..N
  logic [CSR_W-1:0] aux_rdata;
  netctl_aux_bank #(.DATA_W(CSR_W), .SEL_W(SEL_W)) u_aux (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (aux_we),
    .sel   (sel_q),
    .wdata (host_wdata),
    .rdata (aux_rdata)
  );

  // summaries
  logic err_sum, irq_sum;
  assign err_sum = stat_q[EV_BABBLE] | stat_q[EV_COLL] |
                   stat_q[EV_MISSED] | stat_q[EV_MEMERR];
  assign irq_sum = stat_q[EV_BABBLE] | stat_q[EV_MISSED] | stat_q[EV_MEMERR] |
                   stat_q[EV_RXINT]  | stat_q[EV_TXINT]  | stat_q[EV_INITDONE];

  always_comb begin
    csr_value                        = '0;
    csr_value[BIT_ERRSUM]            = err_sum;
    csr_value[EVT_BASE +: N_EVT]     = stat_q;
    csr_value[BIT_IRQSUM]            = irq_sum;
    csr_value[BIT_IEN]               = cmd_q.inea;
    csr_value[BIT_RXON]              = cmd_q.rxon;
    csr_value[BIT_TXON]              = cmd_q.txon;
    csr_value[BIT_TXDEMAND]          = cmd_q.tdmd;
    csr_value[BIT_STOP]              = cmd_q.stop;
    csr_value[BIT_START]             = cmd_q.start;
    csr_value[BIT_INIT]              = cmd_q.init;
  end

  always_comb begin
    if (host_addr)          host_rdata = CSR_W'(sel_q);
    else if (sel_q == '0)   host_rdata = csr_value;
    else                    host_rdata = aux_rdata;
  end

  assign ctl_start = cmd_q.start;
  assign ctl_stop  = cmd_q.stop;
  assign ctl_init  = cmd_q.init;
  assign ctl_tdmd  = cmd_q.tdmd;
  assign ctl_inea  = cmd_q.inea;
  assign rx_on     = cmd_q.rxon;
  assign tx_on     = cmd_q.txon;
  assign irq       = irq_sum & cmd_q.inea;
endmodule

// File: rtl/netctl_csr_chk.sv
module netctl_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr0_we,
  input logic [15:0] host_wdata,
  input logic [15:0] csr_value,
  input logic        irq,
  input logic        ev_babble,
  input logic        ev_rxdone
);
  AST_RXINT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_we && host_wdata[10] && !ev_rxdone |=> !csr_value[10]); // R1

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babble |=> csr_value[14]); // R2

  AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_we && host_wdata[2] |=> csr_value[2] && !csr_value[1] && !csr_value[0]); // R4

  AST_IEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_we |=> csr_value[6] == $past(host_wdata[6])); // R5

  AST_MEMERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    csr_value[11] |-> !csr_value[5] && !csr_value[4]); // R7

  AST_STOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_value[2] |-> !csr_value[8]); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxdone && csr_value[6] && !csr0_we |=> irq); // R9
endmodule

bind netctl_csr netctl_csr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .csr0_we    (csr0_we),
  .host_wdata (host_wdata),
  .csr_value  (csr_value),
  .irq        (irq),
  .ev_babble  (ev_babble),
  .ev_rxdone  (ev_rxdone)
);

// File: tb/netctl_csr_bench.sv
`timescale 1ns/1ps
module netctl_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we, host_addr;
  logic [15:0] host_wdata, host_rdata, csr_value;
  logic        ev_babble, ev_coll, ev_miss, ev_merr, ev_rxdone, ev_txdone, ev_initdone;
  logic        init_rx_en, init_tx_en, tdmd_clr;
  logic        ctl_start, ctl_stop, ctl_init, ctl_tdmd, ctl_inea, rx_on, tx_on, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  netctl_csr u_netctl_csr (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_babble(ev_babble), .ev_coll(ev_coll), .ev_miss(ev_miss), .ev_merr(ev_merr),
    .ev_rxdone(ev_rxdone), .ev_txdone(ev_txdone), .ev_initdone(ev_initdone),
    .init_rx_en(init_rx_en), .init_tx_en(init_tx_en), .tdmd_clr(tdmd_clr),
    .csr_value(csr_value), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .ctl_init(ctl_init), .ctl_tdmd(ctl_tdmd), .ctl_inea(ctl_inea),
    .rx_on(rx_on), .tx_on(tx_on), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // one clock of stimulus; ev = {babble,coll,miss,merr,rxdone,txdone,initdone}
  task automatic cyc(logic we, logic addr, logic [15:0] d, logic [6:0] ev,
                     logic tclr, logic rxe, logic txe);
    host_we = we; host_addr = addr; host_wdata = d;
    {ev_babble, ev_coll, ev_miss, ev_merr, ev_rxdone, ev_txdone, ev_initdone} = ev;
    tdmd_clr = tclr; init_rx_en = rxe; init_tx_en = txe;
    @(negedge clk);
    host_we = 1'b0; host_addr = 1'b0; ev_babble = 0; ev_coll = 0; ev_miss = 0;
    ev_merr = 0; ev_rxdone = 0; ev_txdone = 0; ev_initdone = 0; tdmd_clr = 0;
  endtask

  task automatic wr(logic addr, logic [15:0] d);
    cyc(1'b1, addr, d, 7'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pulse(logic [6:0] ev);
    cyc(1'b0, 1'b0, 16'h0, ev, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(logic addr, output logic [15:0] v);
    host_addr = addr;
    #1 v = host_rdata;
    host_addr = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R10 word0", csr_value, 16'h0004);
    chk("R10 irq", {15'b0, irq}, 16'h0);
    rd(1'b1, v); chk("R10 select", v, 16'h0);
    rd(1'b0, v); chk("R10 window", v, 16'h0004);
    wr(1'b1, 16'h0003); rd(1'b0, v); chk("R10 sel3", v, 16'h0);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_select;
    logic [15:0] v;
    wr(1'b1, 16'h0005); rd(1'b1, v); chk("R11 select masked", v, 16'h0001);
    wr(1'b0, 16'hA5A5);
    wr(1'b1, 16'h0002); wr(1'b0, 16'h1234);
    wr(1'b1, 16'h0003); wr(1'b0, 16'hFFFF);
    wr(1'b1, 16'h0001); rd(1'b0, v); chk("R11 sel1", v, 16'hA5A5);
    wr(1'b1, 16'h0002); rd(1'b0, v); chk("R11 sel2", v, 16'h1234);
    wr(1'b1, 16'h0003); rd(1'b0, v); chk("R11 sel3", v, 16'hFFFF);
    wr(1'b1, 16'h0000); rd(1'b0, v); chk("R11 sel0 untouched", v, 16'h0004);
  endtask

  task automatic t_commands;
    wr(1'b0, 16'h0002); chk("R3 start clears stop", csr_value, 16'h0002);
    wr(1'b0, 16'h0000); chk("R3 zero keeps start", csr_value, 16'h0002);
    wr(1'b0, 16'h0001); chk("R3 init set", csr_value, 16'h0003);
    wr(1'b0, 16'h0004); chk("R4 stop clears", csr_value, 16'h0004);
    wr(1'b0, 16'h0007); chk("R4 stop priority", csr_value, 16'h0004);
    chk("R4 ctl pins", {13'b0, ctl_start, ctl_stop, ctl_init}, 16'h0002);
    wr(1'b0, 16'h0008); chk("R3 demand set", csr_value, 16'h000C);
    cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 ack clears demand", csr_value, 16'h0004);
    cyc(1'b1, 1'b0, 16'h0008, 7'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 host set wins", {15'b0, ctl_tdmd}, 16'h0001);
    cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 cleared again", csr_value, 16'h0004);
  endtask

  task automatic t_enable;
    wr(1'b0, 16'h0040); chk("R5 enable on", csr_value, 16'h0044);
    chk("R9 no irq without summary", {15'b0, irq}, 16'h0);
    wr(1'b0, 16'h0000); chk("R5 enable off", csr_value, 16'h0004);
  endtask

  task automatic t_events;
    wr(1'b0, 16'h0042); chk("R3 running", csr_value, 16'h0042);
    pulse(7'b0000100); chk("R2 rx flag", csr_value, 16'h04C2);
    chk("R9 irq", {15'b0, irq}, 16'h0001);
    wr(1'b0, 16'h0440); chk("R1 rx clear", csr_value, 16'h0042);
    chk("R9 irq drops", {15'b0, irq}, 16'h0);
    pulse(7'b0100000); chk("R6 collision no irq summary", csr_value, 16'hA042);
    chk("R9 collision no irq", {15'b0, irq}, 16'h0);
    wr(1'b0, 16'h2040); chk("R1 collision clear", csr_value, 16'h0042);
    cyc(1'b1, 1'b0, 16'h4040, 7'b1000000, 1'b0, 1'b0, 1'b0);
    chk("R2 set beats clear", csr_value, 16'hC0C2);
    wr(1'b0, 16'h4040); chk("R1 babble clear", csr_value, 16'h0042);
  endtask

  task automatic t_init_merr;
    wr(1'b0, 16'h0041); chk("R3 init while running", csr_value, 16'h0043);
    cyc(1'b0, 1'b0, 16'h0, 7'b0000001, 1'b0, 1'b1, 1'b1);
    chk("R8 init done loads", csr_value, 16'h01F2);
    wr(1'b0, 16'h0140); chk("R1 done clear", csr_value, 16'h0072);
    pulse(7'b0001000); chk("R7 memory error stops rx tx", csr_value, 16'h88C2);
    chk("R7 pins", {14'b0, rx_on, tx_on}, 16'h0);
    wr(1'b0, 16'h0840); chk("R1 merr clear", csr_value, 16'h0042);
    wr(1'b0, 16'h0004); chk("R4 stop", csr_value, 16'h0004);
    cyc(1'b0, 1'b0, 16'h0, 7'b0000001, 1'b0, 1'b0, 1'b1);
    chk("R8 done held clear while stopped", csr_value, 16'h0014);
  endtask

  initial begin
    host_we = 0; host_addr = 0; host_wdata = 0;
    ev_babble = 0; ev_coll = 0; ev_miss = 0; ev_merr = 0;
    ev_rxdone = 0; ev_txdone = 0; ev_initdone = 0;
    init_rx_en = 0; init_tx_en = 0; tdmd_clr = 0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_select;
    t_commands;
    t_enable;
    t_events;
    t_init_merr;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule